// File: doc/BRIEF.md
# Two-Write-Port Register File with Zero Register

This block holds the architectural integer registers of a pipelined processor core. It has two independent read ports for the operands of the decode stage and two write ports for results retiring from two producers. The sequencer or issue logic decides which producer drives each write port, and that choice is made outside this block. A value being written in a cycle is already visible to a read of the same register in that cycle. Decode therefore never sees a stale operand for a result that is retiring in the same cycle.

Register zero is a constant. It always reads as zero, and any write aimed at it is dropped. This lets an instruction word of all zeros, which adds register zero to itself into register zero, act as a no-op that leaves no trace in the file. When both write ports name the same nonzero register in one cycle, the first write port wins. This holds both for the stored value and for the same-cycle read.

Top module: `rf_dual_wr`

## Requirements
- R1: A synchronous active-high reset sets every register to zero. After reset, every address reads as zero until it is written.
- R2: With `wr0_en` high, `wr0_data` is stored into register `wr0_addr` at the rising edge. From the next cycle on it is returned on both read ports.
- R3: With `wr1_en` high, `wr1_data` is stored into register `wr1_addr` at the rising edge. From the next cycle on it is returned on both read ports.
- R4: Both write ports can write two different nonzero registers in the same cycle, and both values are kept.
- R5: If a read address equals the address of an enabled write in the same cycle, the read port returns that cycle's write data rather than the stored value. This works for either read port and either write port.
- R6: Address 0 always reads as zero on both read ports, even while a write to address 0 is being presented.
- R7: Writes to address 0 are discarded on either write port, and no other register changes. An all-zero no-op, which writes register 0 on both ports, leaves the whole file unchanged.
- R8: When both write ports are enabled for the same nonzero register, write port 0's data is stored. Port 0's data is also the value bypassed to a same-cycle read.
- R9: With a write enable low, its address and data have no effect. Nothing is stored and nothing is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_addr | input | 5 | Read port 0 register index |
| rd1_addr | input | 5 | Read port 1 register index |
| wr0_en | input | 1 | Write port 0 enable (priority port) |
| wr0_addr | input | 5 | Write port 0 register index |
| wr0_data | input | 32 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 5 | Write port 1 register index |
| wr1_data | input | 32 | Write port 1 data |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_data | output | 32 | Read port 1 data, combinational |

## Verification
The hardest situations to reach are those where several addresses line up in one cycle. Examples are both writes and a read all naming the same register, or a write to register zero being presented while register zero is read. Random stimulus over 32 addresses rarely produces these. Directed cycles therefore set them up explicitly, and the same register is read again on the following cycle to show what was actually stored. A random phase then draws addresses from a narrow pool of four registers, including zero, so that collisions and bypass hits occur often.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);
    localparam int NWP  = 2;
    localparam int NRP  = 2;

    typedef logic [AW-1:0]   reg_idx_t;
    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic     en;
        reg_idx_t idx;
        word_t    data;
    } wr_req_t;

    function automatic logic is_zero_idx(reg_idx_t a);
        return a == '0;
    endfunction

    function automatic logic req_hits(wr_req_t q, reg_idx_t a);
        return q.en && (q.idx == a);
    endfunction

endpackage

// File: rtl/rf_wr_filter.sv
// Cleans raw write requests: drops writes to the zero register and
// drops a lower-priority port that collides with a higher-priority one.
module rf_wr_filter
    import rf_pkg::*;
(
    input  wr_req_t raw   [NWP],
    output wr_req_t clean [NWP]
);

    always_comb begin
        for (int p = 0; p < NWP; p++) begin
            clean[p]    = raw[p];
            clean[p].en = raw[p].en && !is_zero_idx(raw[p].idx);
            for (int q = 0; q < p; q++) begin
                if (raw[q].en && !is_zero_idx(raw[q].idx) &&
                    (raw[q].idx == raw[p].idx)) begin
                    clean[p].en = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rf_store.sv
// Flop array; entry 0 is a constant zero.
module rf_store
    import rf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr   [NWP],
    output word_t   regs [NREG]
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign regs[r] = '0;
        end else begin : g_flop
            word_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    // descending order: lowest port assigned last, wins
                    for (int p = NWP - 1; p >= 0; p--) begin
                        if (req_hits(wr[p], reg_idx_t'(r))) begin
                            q <= wr[p].data;
                        end
                    end
                end
            end
            assign regs[r] = q;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
// One read port with same-cycle bypass from the cleaned write requests.
module rf_read_port
    import rf_pkg::*;
(
    input  reg_idx_t addr,
    input  wr_req_t  wr   [NWP],
    input  word_t    regs [NREG],
    output word_t    data
);

    always_comb begin
        data = regs[addr];
        for (int p = NWP - 1; p >= 0; p--) begin
            if (req_hits(wr[p], addr)) begin
                data = wr[p].data;
            end
        end
        if (is_zero_idx(addr)) begin
            data = '0;
        end
    end

endmodule

// File: rtl/rf_dual_wr.sv
module rf_dual_wr
    import rf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd0_addr,
    input  logic [AW-1:0]   rd1_addr,
    input  logic            wr0_en,
    input  logic [AW-1:0]   wr0_addr,
    input  logic [XLEN-1:0] wr0_data,
    input  logic            wr1_en,
    input  logic [AW-1:0]   wr1_addr,
    input  logic [XLEN-1:0] wr1_data,
    output logic [XLEN-1:0] rd0_data,
    output logic [XLEN-1:0] rd1_data
);

    wr_req_t  raw_req   [NWP];
    wr_req_t  clean_req [NWP];
    word_t    regs      [NREG];
    reg_idx_t rd_addr   [NRP];
    word_t    rd_data   [NRP];

    assign raw_req[0] = '{en: wr0_en, idx: wr0_addr, data: wr0_data};
    assign raw_req[1] = '{en: wr1_en, idx: wr1_addr, data: wr1_data};

    assign rd_addr[0] = rd0_addr;
    assign rd_addr[1] = rd1_addr;
    assign rd0_data   = rd_data[0];
    assign rd1_data   = rd_data[1];

    rf_wr_filter u_filter (
        .raw   (raw_req),
        .clean (clean_req)
    );

    rf_store u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (clean_req),
        .regs (regs)
    );

    for (genvar k = 0; k < NRP; k++) begin : g_rd
        rf_read_port u_rd (
            .addr (rd_addr[k]),
            .wr   (clean_req),
            .regs (regs),
            .data (rd_data[k])
        );
    end

endmodule

// File: rtl/rf_dual_wr_chk.sv
module rf_dual_wr_chk
    import rf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   rd0_addr,
    input logic [AW-1:0]   rd1_addr,
    input logic            wr0_en,
    input logic [AW-1:0]   wr0_addr,
    input logic [XLEN-1:0] wr0_data,
    input logic            wr1_en,
    input logic [AW-1:0]   wr1_addr,
    input logic [XLEN-1:0] wr1_data,
    input logic [XLEN-1:0] rd0_data,
    input logic [XLEN-1:0] rd1_data
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !(wr0_en && wr0_addr == rd0_addr) &&
         !(wr1_en && wr1_addr == rd0_addr)) |-> rd0_data == '0); // R1

    AST_ZERO_READ0: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr == '0) |-> rd0_data == '0); // R6

    AST_ZERO_READ1: assert property (@(posedge clk) disable iff (rst)
        (rd1_addr == '0) |-> rd1_data == '0); // R6

    AST_BYPASS_WP0: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr0_addr != '0 && rd0_addr == wr0_addr) |-> rd0_data == wr0_data); // R5

    AST_BYPASS_WP1: assert property (@(posedge clk) disable iff (rst)
        (wr1_en && wr1_addr != '0 && rd1_addr == wr1_addr &&
         !(wr0_en && wr0_addr == wr1_addr)) |-> rd1_data == wr1_data); // R5

    AST_COLLIDE_WIN: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr1_en && wr0_addr != '0 && wr0_addr == wr1_addr &&
         rd1_addr == wr0_addr) |-> rd1_data == wr0_data); // R8

    AST_STORE_WP0: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr0_en && wr0_addr != '0) && rd0_addr == $past(wr0_addr) &&
         !(wr0_en && wr0_addr == rd0_addr) && !(wr1_en && wr1_addr == rd0_addr))
        |-> rd0_data == $past(wr0_data)); // R2

    AST_STORE_WP1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr1_en && wr1_addr != '0 && !(wr0_en && wr0_addr == wr1_addr)) &&
         rd1_addr == $past(wr1_addr) &&
         !(wr0_en && wr0_addr == rd1_addr) && !(wr1_en && wr1_addr == rd1_addr))
        |-> rd1_data == $past(wr1_data)); // R3

endmodule

bind rf_dual_wr rf_dual_wr_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .rd0_addr (rd0_addr),
    .rd1_addr (rd1_addr),
    .wr0_en   (wr0_en),
    .wr0_addr (wr0_addr),
    .wr0_data (wr0_data),
    .wr1_en   (wr1_en),
    .wr1_addr (wr1_addr),
    .wr1_data (wr1_data),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data)
);

// File: tb/test_rf_dual_wr.sv
module test_rf_dual_wr;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd0_addr, rd1_addr, wr0_addr, wr1_addr;
    logic        wr0_en, wr1_en;
    logic [31:0] wr0_data, wr1_data, rd0_data, rd1_data;

    always #2 clk = ~clk;

    rf_dual_wr i_rf_dual_wr (
        .clk(clk), .rst(rst),
        .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd0_data(rd0_data), .rd1_data(rd1_data)
    );

    typedef struct {
        logic [31:0] exp0;
        logic [31:0] exp1;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [31:0] model [32];
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    function automatic logic [31:0] predict(logic [4:0] a);
        if (a == 5'd0) return 32'd0;
        if (wr0_en && wr0_addr == a) return wr0_data;
        if (wr1_en && wr1_addr == a) return wr1_data;
        return model[a];
    endfunction

    // driver: presents one cycle of stimulus and queues the expected reads
    task automatic step(input bit r, input logic [4:0] a0, input logic [4:0] a1,
                        input bit e0, input logic [4:0] w0, input logic [31:0] d0,
                        input bit e1, input logic [4:0] w1, input logic [31:0] d1,
                        input string tag, input bit chk);
        item_t it;
        @(negedge clk);
        rst = r; rd0_addr = a0; rd1_addr = a1;
        wr0_en = e0; wr0_addr = w0; wr0_data = d0;
        wr1_en = e1; wr1_addr = w1; wr1_data = d1;
        if (chk) begin
            it.exp0 = predict(a0);
            it.exp1 = predict(a1);
            it.tag  = tag;
            sb_q.push_back(it);
        end
        if (r) begin
            for (int i = 0; i < 32; i++) model[i] = 32'd0;
        end else begin
            if (e1 && w1 != 5'd0) model[w1] = d1;
            if (e0 && w0 != 5'd0) model[w0] = d0;
        end
    endtask

    task automatic rd(input logic [4:0] a0, input logic [4:0] a1, input string tag);
        step(1'b0, a0, a1, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 32'd0, tag, 1'b1);
    endtask

    // monitor: samples midway between the driving edge and the capturing edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_run += 2;
                if (rd0_data !== it.exp0) begin
                    n_fail++;
                    $display("FAIL %s rd0: actual %h expected %h", it.tag, rd0_data, it.exp0);
                end
                if (rd1_data !== it.exp1) begin
                    n_fail++;
                    $display("FAIL %s rd1: actual %h expected %h", it.tag, rd1_data, it.exp1);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'hx;
        rst = 1'b1;
        rd0_addr = '0; rd1_addr = '0;
        wr0_en = 0; wr0_addr = '0; wr0_data = '0;
        wr1_en = 0; wr1_addr = '0; wr1_data = '0;
        for (int i = 0; i < 3; i++)
            step(1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 32'd0, "rst", 1'b0);

        // R1: every register reads zero after reset
        for (int i = 0; i < 16; i++) rd(5'(2*i), 5'(2*i+1), "R1");

        // R2: port 0 write, visible on both read ports next cycle
        step(0, 5'd1, 5'd2, 1, 5'd5, 32'hA5A5_0005, 0, 5'd0, 32'd0, "R2", 1);
        rd(5'd5, 5'd5, "R2");

        // R3: port 1 write
        step(0, 5'd1, 5'd2, 0, 5'd0, 32'd0, 1, 5'd9, 32'h1234_0009, "R3", 1);
        rd(5'd9, 5'd9, "R3");

        // R4: two distinct registers in one cycle
        step(0, 5'd3, 5'd4, 1, 5'd10, 32'hDEAD_000A, 1, 5'd11, 32'hBEEF_000B, "R4", 1);
        rd(5'd10, 5'd11, "R4");

        // R5: same-cycle bypass from each write port to each read port
        step(0, 5'd12, 5'd13, 1, 5'd12, 32'h0C0C_0C0C, 1, 5'd13, 32'h0D0D_0D0D, "R5", 1);
        step(0, 5'd21, 5'd20, 1, 5'd20, 32'h2020_2020, 1, 5'd21, 32'h2121_2121, "R5", 1);
        rd(5'd12, 5'd21, "R5");

        // R6/R7: all-zero no-op style writes to register 0 on both ports
        step(0, 5'd0, 5'd0, 1, 5'd0, 32'hFFFF_FFFF, 1, 5'd0, 32'h7777_7777, "R6", 1);
        rd(5'd0, 5'd0, "R7");
        step(0, 5'd0, 5'd5, 1, 5'd0, 32'h0, 1, 5'd0, 32'h0, "R7", 1);
        rd(5'd5, 5'd9, "R7");
        rd(5'd10, 5'd11, "R7");

        // R8: collision, port 0 wins for bypass and storage
        step(0, 5'd14, 5'd14, 1, 5'd14, 32'hAAAA_0000, 1, 5'd14, 32'hBBBB_0000, "R8", 1);
        rd(5'd14, 5'd14, "R8");

        // R9: disabled writes neither store nor bypass
        step(0, 5'd5, 5'd9, 0, 5'd5, 32'h5555_5555, 0, 5'd9, 32'h9999_9999, "R9", 1);
        rd(5'd5, 5'd9, "R9");

        // R5/R8 random mix over a narrow register pool to force hits
        for (int i = 0; i < 300; i++) begin
            logic [4:0] pool [4];
            pool = '{5'd0, 5'd3, 5'd14, 5'd30};
            step(0, pool[$urandom_range(3)], pool[$urandom_range(3)],
                 1'($urandom_range(1)), pool[$urandom_range(3)], $urandom,
                 1'($urandom_range(1)), pool[$urandom_range(3)], $urandom,
                 "R5_R8_mix", 1);
        end

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule